// File: doc/BRIEF.md
# I2C Colour-Table Register Slave

This block is a two-wire serial slave that answers one fixed 7-bit device address and gives a bus master access to three storage spaces: a small file of control registers with two read-only status slots, a colour look-up table of 256 entries that each hold a red, a green and a blue byte, and a 256-byte cursor bitmap. The master selects a space with the first data byte of a write transfer, the subaddress. Ordinary subaddresses reach the control registers and step forward after every data byte. Two reserved subaddresses open streaming ports into the table and the bitmap. Through a port, the first byte sets the entry pointer and the following bytes fill entries one after another.

The bus lines are sampled by the system clock through a synchronizer. The open-drain data line is modelled as an input plus an output-enable that pulls the line low. A start or repeated start always restarts byte framing, and a stop returns the block to rest.

The protocol engine has nine states. ST_IDLE waits for a start. ST_ADDR shifts in the address byte and moves to ST_ADDR_ACK when it matches, or back to ST_IDLE when it does not. From ST_ADDR_ACK a write goes to ST_SUB and a read goes to ST_RD. ST_SUB takes the subaddress and moves to ST_SUB_ACK, then to ST_WR. ST_WR and ST_WR_ACK alternate for every byte written. ST_RD and ST_RD_ACK alternate for every byte read, and ST_RD_ACK leaves for ST_IDLE when the master does not acknowledge. A start event moves every state to ST_ADDR, and a stop event moves every state to ST_IDLE.

Top module: `colour_port_i2c`

## Requirements
- R1: Only address byte 0x88 (write) or 0x89 (read), which is 7-bit address 0x44 followed by the direction bit, is acknowledged. Any other address gets no acknowledge, and the bytes that follow change nothing.
- R2: After a matching address, the slave pulls SDA low (sda_oe=1) during the ninth clock of the address byte, of the subaddress byte and of every written byte. At all other times it leaves the line released, except while it sends read data.
- R3: Subaddresses 0x00 to 0x0D are read/write control bytes. Byte n appears on ctrl_q[8n+7:8n], and all of them are zero after reset. The subaddress steps by one after every byte written or read. A read of a subaddress from 0x10 to 0xFD returns 0x00.
- R4: Subaddress 0x0E reads status0_i and subaddress 0x0F reads status1_i. Writes to these two subaddresses are ignored.
- R5: After subaddress 0xFF, the first written byte sets the table pointer. Each later group of three bytes is stored as red, green and blue of that entry, and then the pointer steps by one, wrapping from 0xFF to 0x00. The register subaddress does not move while a port is open.
- R6: A start, repeated start or stop that arrives before the third byte of a group discards the one or two colour bytes already received. The table entry keeps its old value, and the next group starts again at red.
- R7: After subaddress 0xFE, the first written byte sets the bitmap pointer. Each later byte is stored at the pointer, and the pointer then steps by one, wrapping at 0xFF.
- R8: A read through a port returns the bytes at the current pointer. For the table, a read returns red, green and blue of one entry and then steps the pointer. For the bitmap, a read returns one byte per entry.
- R9: A master that does not acknowledge a read byte ends the data phase: the slave releases SDA and ignores clocks until the next start. After a stop, clocked bytes that come without a start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, pull the data line low |
| status0_i | input | 8 | Read-only status byte at subaddress 0x0E |
| status1_i | input | 8 | Read-only status byte at subaddress 0x0F |
| ctrl_q | output | 112 | Control bytes 0x00 to 0x0D, byte n in bits 8n+7:8n |

## Verification
The hardest case to reach is a colour group cut short. To reach it, the master must open the table port, load a pointer, send one or two colour bytes and then break the transfer. Nothing at the ports shows that the partial bytes were dropped until the entry is read back. The stimulus first writes known triplets to two entries. It then breaks one group with a repeated start and another with a stop, and reads both entries back through the port, where the old values must still be present. The pointer sweep also runs across 0xFF so that the wrap of the table and bitmap pointers is observed.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
        ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
    } st_t;

    typedef enum logic [1:0] {SP_REG, SP_LUT, SP_CUR} space_t;

    localparam logic [7:0] SUB_LUT = 8'hFF;
    localparam logic [7:0] SUB_CUR = 8'hFE;
endpackage

// File: rtl/i2cp_line_sync.sv
module i2cp_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_d, sda_d, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_ff[SYNC_STAGES-1];
            sda_d  <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_s    = scl_ff[SYNC_STAGES-1];
    assign sda_s    = sda_ff[SYNC_STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cp_store.sv
module i2cp_store
    import i2cp_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic                     lut_we,
    input  logic                     cur_we,
    input  space_t                   space,
    input  logic [7:0]               sub,
    input  logic [7:0]               ptr,
    input  logic [1:0]               tri_idx,
    input  logic [7:0]               wdata,
    input  logic [23:0]              wrgb,
    input  logic [7:0]               st0,
    input  logic [7:0]               st1,
    output logic [7:0]               rdata,
    output logic [(NREG-2)*8-1:0]    ctrl_q
);
    localparam int NCTRL = NREG - 2;

    logic [7:0] ctrl_r [NCTRL];
    logic [7:0] lut_r [256];
    logic [7:0] lut_g [256];
    logic [7:0] lut_b [256];
    logic [7:0] cur_m [256];

    for (genvar i = 0; i < NCTRL; i++) begin : g_ctrl
        localparam logic [7:0] IDX = 8'(i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     ctrl_r[i] <= '0;
            else if (reg_we && sub == IDX)  ctrl_r[i] <= wdata;
        end
        assign ctrl_q[8*i +: 8] = ctrl_r[i];
    end

    always_ff @(posedge clk) begin
        if (lut_we) begin
            lut_r[ptr] <= wrgb[23:16];
            lut_g[ptr] <= wrgb[15:8];
            lut_b[ptr] <= wrgb[7:0];
        end
        if (cur_we) cur_m[ptr] <= wdata;
    end

    always_comb begin
        rdata = '0;
        unique case (space)
            SP_REG: begin
                for (int i = 0; i < NCTRL; i++)
                    if (sub == 8'(i)) rdata = ctrl_r[i];
                if (sub == 8'(NREG-2)) rdata = st0;
                if (sub == 8'(NREG-1)) rdata = st1;
            end
            SP_LUT: begin
                unique case (tri_idx)
                    2'd0:    rdata = lut_r[ptr];
                    2'd1:    rdata = lut_g[ptr];
                    2'd2:    rdata = lut_b[ptr];
                    default: rdata = '0;
                endcase
            end
            SP_CUR:  rdata = cur_m[ptr];
            default: rdata = '0;
        endcase
    end

    // the two status slots and all unmapped slots hold nothing writable
    assert_status_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sub >= 8'(NCTRL)) |=> $stable(ctrl_q));
endmodule

// File: rtl/colour_port_i2c.sv
module colour_port_i2c
    import i2cp_pkg::*;
#(
    parameter int         NREG        = 16,
    parameter logic [6:0] DEV_ADDR    = 7'h44,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [7:0]            status0_i,
    input  logic [7:0]            status1_i,
    output logic [(NREG-2)*8-1:0] ctrl_q
);
    st_t        state, nxt;
    space_t     space_q;
    logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [3:0] cnt;
    logic [7:0] sh, tx, sub_q, ptr_q, hold_r, hold_g, rdata;
    logic [7:0] rd_sub, rd_ptr;
    logic [1:0] tri_q, rd_tri;
    logic       rw, ack_rx, pend;
    logic       byte_done, wr_fire, load, reg_we, lut_we, cur_we;

    i2cp_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    assign byte_done = scl_fall && (cnt == 4'd8);
    assign wr_fire   = (state == ST_WR) && byte_done;
    assign reg_we    = wr_fire && (space_q == SP_REG);
    assign lut_we    = wr_fire && (space_q == SP_LUT) && !pend && (tri_q == 2'd2);
    assign cur_we    = wr_fire && (space_q == SP_CUR) && !pend;
    assign load      = scl_fall && (((state == ST_ADDR_ACK) && rw) ||
                                    ((state == ST_RD_ACK) && !ack_rx));

    i2cp_store #(.NREG(NREG)) u_store (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .lut_we(lut_we),
        .cur_we(cur_we), .space(space_q), .sub(sub_q), .ptr(ptr_q),
        .tri_idx(tri_q), .wdata(sh), .wrgb({hold_r, hold_g, sh}),
        .st0(status0_i), .st1(status1_i), .rdata(rdata), .ctrl_q(ctrl_q)
    );

    // pointer advance after a byte is fetched for reading
    always_comb begin
        rd_sub = sub_q;
        rd_ptr = ptr_q;
        rd_tri = tri_q;
        unique case (space_q)
            SP_REG: rd_sub = sub_q + 8'd1;
            SP_LUT: begin
                if (tri_q == 2'd2) begin
                    rd_tri = 2'd0;
                    rd_ptr = ptr_q + 8'd1;
                end else begin
                    rd_tri = tri_q + 2'd1;
                end
            end
            SP_CUR:  rd_ptr = ptr_q + 8'd1;
            default: ;
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_ev)       nxt = ST_IDLE;
        else if (start_ev) nxt = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done) nxt = (sh[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall)  nxt = rw ? ST_RD : ST_SUB;
                ST_SUB:      if (byte_done) nxt = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall)  nxt = ST_WR;
                ST_WR:       if (byte_done) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)  nxt = ST_WR;
                ST_RD:       if (scl_fall && cnt == 4'd7) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)  nxt = ack_rx ? ST_IDLE : ST_RD;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; sh <= '0; tx <= '0; rw <= 1'b0; ack_rx <= 1'b0;
            sub_q <= '0; space_q <= SP_REG; pend <= 1'b0; ptr_q <= '0;
            tri_q <= '0; hold_r <= '0; hold_g <= '0; sda_oe <= 1'b0;
        end else if (stop_ev || start_ev) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            tri_q  <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_SUB, ST_WR: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (state == ST_ADDR) begin
                            rw     <= sh[0];
                            sda_oe <= (sh[7:1] == DEV_ADDR);
                        end else begin
                            sda_oe <= 1'b1;
                        end
                        if (state == ST_SUB) begin
                            sub_q   <= sh;
                            pend    <= (sh == SUB_LUT) || (sh == SUB_CUR);
                            space_q <= (sh == SUB_LUT) ? SP_LUT :
                                       (sh == SUB_CUR) ? SP_CUR : SP_REG;
                        end
                        if (state == ST_WR) begin
                            unique case (space_q)
                                SP_REG: sub_q <= sub_q + 8'd1;
                                SP_LUT: begin
                                    if (pend) begin
                                        ptr_q <= sh;
                                        pend  <= 1'b0;
                                    end else if (tri_q == 2'd2) begin
                                        ptr_q <= ptr_q + 8'd1;
                                        tri_q <= 2'd0;
                                    end else begin
                                        if (tri_q == 2'd0) hold_r <= sh;
                                        else               hold_g <= sh;
                                        tri_q <= tri_q + 2'd1;
                                    end
                                end
                                SP_CUR: begin
                                    if (pend) begin
                                        ptr_q <= sh;
                                        pend  <= 1'b0;
                                    end else begin
                                        ptr_q <= ptr_q + 8'd1;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                end
                ST_ADDR_ACK, ST_SUB_ACK, ST_WR_ACK, ST_RD_ACK: begin
                    if (scl_rise && state == ST_RD_ACK) ack_rx <= sda_s;
                    if (scl_fall) begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        if (load) begin
                            tx     <= rdata;
                            sda_oe <= ~rdata[7];
                            sub_q  <= rd_sub;
                            ptr_q  <= rd_ptr;
                            tri_q  <= rd_tri;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                        end else begin
                            tx     <= tx << 1;
                            sda_oe <= ~tx[6];
                            cnt    <= cnt + 4'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assert_oe_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> state inside {ST_ADDR_ACK, ST_SUB_ACK, ST_WR_ACK, ST_RD});
    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE) && !sda_oe);
    assert_start_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (state == ST_ADDR) && (tri_q == 2'd0));
    assert_tri_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tri_q != 2'd3);
    assert_lut_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lut_we |=> ptr_q == $past(ptr_q) + 8'd1);
    assert_sub_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (space_q != SP_REG && state != ST_SUB) |=> $stable(sub_q));
endmodule

// File: tb/colour_port_i2c_test.sv
module colour_port_i2c_test;
    localparam int Q     = 6;
    localparam int NCTRL = 14;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, scl_m, sda_m;
    logic [7:0] st0, st1;
    logic sda_oe;
    logic [NCTRL*8-1:0] ctrl_q;
    wire bus_sda = sda_m & ~sda_oe;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    colour_port_i2c uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
        .sda_oe(sda_oe), .status0_i(st0), .status1_i(st1), .ctrl_q(ctrl_q)
    );

    function automatic int regv(int i);  return (i * 37 + 5) & 255; endfunction
    function automatic int lutv(int e, int k); return (e * 7 + k * 85 + 1) & 255; endfunction
    function automatic int curv(int i);  return ((i * 11) ^ 8'h5A) & 255; endfunction

    task automatic chk(string req, int act, int exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(); scl_m = 1'b1; hold(); hold(); scl_m = 1'b0;
        end
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        ack = ~bus_sda;
        hold(); scl_m = 1'b0; hold();
    endtask

    task automatic recv(input bit nak, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hold(); scl_m = 1'b1; hold();
            b = {b[6:0], bus_sda};
            hold(); scl_m = 1'b0;
        end
        sda_m = nak; hold(); scl_m = 1'b1; hold(); hold(); scl_m = 1'b0; hold();
        sda_m = 1'b1;
    endtask

    task automatic wack(input logic [7:0] b, string req);
        bit a;
        send(b, a);
        chk(req, int'(a), 1);
    endtask

    initial begin
        logic [7:0] rb;
        bit a;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; st0 = 8'hA5; st1 = 8'h3C;
        repeat (5) @(negedge clk);
        rst_n = 1'b1; hold();

        // R3 reset state, R2 line released
        for (int i = 0; i < NCTRL; i++) chk("R3 reset", int'(ctrl_q[8*i +: 8]), 0);
        chk("R2 idle release", int'(sda_oe), 0);

        // R1 foreign addresses are ignored
        start_c(); send(8'h50, a); chk("R1 foreign 0x50", int'(a), 0);
        send(8'h00, a); send(8'h77, a); stop_c();
        start_c(); send(8'h8A, a); chk("R1 foreign 0x8A", int'(a), 0);
        send(8'h00, a); send(8'h99, a); stop_c();
        chk("R1 no effect", int'(ctrl_q[7:0]), 0);

        // R3 R4 register write sweep, including the status slots
        start_c(); wack(8'h88, "R1 write addr"); wack(8'h00, "R2 sub");
        for (int i = 0; i < 16; i++) wack(8'(regv(i)), "R2 data");
        stop_c();
        for (int i = 0; i < NCTRL; i++) chk("R3 ctrl byte", int'(ctrl_q[8*i +: 8]), regv(i));

        start_c(); wack(8'h88, "R1"); wack(8'h00, "R2");
        start_c(); wack(8'h89, "R1 read addr");
        for (int i = 0; i < 17; i++) begin
            recv(i == 16, rb);
            if (i < NCTRL)   chk("R3 readback", int'(rb), regv(i));
            else if (i == 14) chk("R4 status0", int'(rb), 8'hA5);
            else if (i == 15) chk("R4 status1", int'(rb), 8'h3C);
            else              chk("R3 unmapped", int'(rb), 0);
        end
        stop_c();

        // R5 table stream across the pointer wrap, R8 readback
        start_c(); wack(8'h88, "R1"); wack(8'hFF, "R5"); wack(8'hF0, "R5");
        for (int e = 0; e < 48; e++)
            for (int k = 0; k < 3; k++) wack(8'(lutv((240 + e) & 255, k)), "R5");
        stop_c();
        start_c(); wack(8'h88, "R1"); wack(8'hFF, "R8"); wack(8'hF0, "R8");
        start_c(); wack(8'h89, "R8");
        for (int e = 0; e < 48; e++)
            for (int k = 0; k < 3; k++) begin
                recv(e == 47 && k == 2, rb);
                chk("R5 R8 table entry", int'(rb), lutv((240 + e) & 255, k));
            end
        stop_c();

        // R6 partial triplets are dropped
        start_c(); wack(8'h88, "R1"); wack(8'hFF, "R6"); wack(8'h30, "R6");
        for (int k = 1; k <= 6; k++) wack(8'(k), "R6");
        stop_c();
        start_c(); wack(8'h88, "R1"); wack(8'hFF, "R6"); wack(8'h31, "R6");
        wack(8'hCC, "R6"); stop_c();
        start_c(); wack(8'h88, "R1"); wack(8'hFF, "R6"); wack(8'h30, "R6");
        wack(8'hAA, "R6"); wack(8'hBB, "R6");
        start_c(); wack(8'h89, "R6");
        for (int k = 1; k <= 6; k++) begin
            recv(k == 6, rb);
            chk("R6 old entry kept", int'(rb), k);
        end
        stop_c();

        // R7 cursor bitmap across the wrap
        start_c(); wack(8'h88, "R1"); wack(8'hFE, "R7"); wack(8'hF8, "R7");
        for (int i = 0; i < 16; i++) wack(8'(curv(i)), "R7");
        stop_c();
        start_c(); wack(8'h88, "R1"); wack(8'hFE, "R7"); wack(8'hF8, "R7");
        start_c(); wack(8'h89, "R7");
        for (int i = 0; i < 16; i++) begin
            recv(i == 15, rb);
            chk("R7 R8 cursor byte", int'(rb), curv(i));
        end
        stop_c();

        // R9 master NACK ends the read, stop returns to rest
        start_c(); wack(8'h88, "R1"); wack(8'h00, "R9");
        start_c(); wack(8'h89, "R9");
        recv(1'b0, rb); chk("R9 first", int'(rb), regv(0));
        recv(1'b1, rb); chk("R9 second", int'(rb), regv(1));
        recv(1'b1, rb); chk("R9 silent after nack", int'(rb), 8'hFF);
        stop_c();
        send(8'h88, a); chk("R9 no ack without start", int'(a), 0);
        start_c(); send(8'h88, a); chk("R1 after recovery", int'(a), 1);
        stop_c();

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vecs++; errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule